// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control half of an 8-bit successive-approximation converter embedded in a microcontroller. Software launches a conversion by writing a zero into the completion bit. The sequencer then empties its working code and resolves one bit per trial, starting at the most significant bit. For each trial it drives a candidate code to an external resistor DAC and reads back a single comparator bit that reports whether the DAC level sits below the analog input.

The conversion always lasts fifty clocks. There is one clearing cycle, then eight trials of six cycles each, then one store cycle. In the store cycle the resolved code is loaded into the result register, the completion bit returns to one and a sticky interrupt request is raised. The DAC is expected to have half-LSB-shifted thresholds: code n maps to a level of (n - 0.5)/256 of full scale for n of 1 or more, and code 0 maps to zero. With those thresholds the final code is the largest code whose level lies strictly below the input.

Top module: `sar_seq`

## Requirements
- R1: While `rst` is high and after it is released, `done` reads 1, `irq` reads 0, and both `result` and `dac_code` read 0x00.
- R2: A cycle with `done_wr`=1 and `done_wdata`=0 starts a conversion, and `done` reads 0 from the next cycle until completion. A write with `done_wdata`=1 changes neither `done`, `result` nor `dac_code`.
- R3: From the cycle after a start until completion, `result` reads 0x00.
- R4: `dac_code` is 0x00 in the clear cycle, in the store cycle and while idle. During a trial it holds the bits already decided, with the bit under test forced to 1. Trials run from bit 7 to bit 0, each lasting six cycles, so the first trial presents 0x80.
- R5: `cmp_in`=1 (DAC level below the input) keeps the bit under test at 1, and `cmp_in`=0 clears it. The comparator is sampled only in the sixth cycle of each trial, and its value in the other five cycles has no effect.
- R6: `done` returns to 1, with the final code in `result`, exactly 50 clock edges after the start edge and not before.
- R7: `irq` is set on the same edge that stores the result.
- R8: `irq` stays 1 until a cycle with `irq_clr`=1 clears it. Starting a conversion does not clear it, and when a store and `irq_clr` fall on the same edge, the set wins.
- R9: A start while a conversion is running restarts it from the clear cycle, and completion then follows 50 edges after the new start.
- R10: With an ideal comparator, the final code equals the largest n (0 to 255) whose DAC level is strictly below the input. Levels are 0 for n=0 and 2n-1 half-LSB units otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| done_wr | input | 1 | Write strobe for the completion bit |
| done_wdata | input | 1 | Value written to the completion bit (0 starts) |
| irq_clr | input | 1 | Software clear of the interrupt request |
| cmp_in | input | 1 | Comparator: 1 when the DAC level is below the input |
| dac_code | output | 8 | Trial code for the external DAC |
| result | output | 8 | Conversion result register |
| done | output | 1 | Completion bit (0 while converting) |
| irq | output | 1 | Sticky interrupt request |

## Verification
The hardest case to reach is a comparator that changes value inside a trial. Only the sixth cycle may matter, and an ideal input level never changes mid-trial, so the port-level model alone cannot reach it. The bench therefore runs a noisy mode that inverts the ideal comparator answer in the first five cycles of every trial, timed by its own count of edges since the start write. The final code must still match the ideal one. The bench also places a restart write deep in a conversion and an interrupt clear on the store edge, then checks the 50-edge timing and the set-over-clear ordering from the ports.

// File: rtl/sar_pkg.sv
package sar_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_CLEAR = 2'd1,
      PH_TRIAL = 2'd2,
      PH_STORE = 2'd3
   } sar_phase_t;

endpackage

// File: rtl/sar_step_timer.sv
module sar_step_timer
   import sar_pkg::*;
#(
   parameter int WIDTH     = 8,
   parameter int TRIAL_CYC = 6,
   parameter int CLR_CYC   = 1,
   parameter int STORE_CYC = 1,
   localparam int IDX_W    = (WIDTH > 1) ? $clog2(WIDTH) : 1,
   localparam int MAX_CYC  = (TRIAL_CYC > CLR_CYC)
                             ? ((TRIAL_CYC > STORE_CYC) ? TRIAL_CYC : STORE_CYC)
                             : ((CLR_CYC > STORE_CYC) ? CLR_CYC : STORE_CYC),
   localparam int CNT_W    = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   output sar_phase_t       phase,
   output logic [IDX_W-1:0] bit_idx,
   output logic             sample,
   output logic             store_fire
);

   localparam logic [CNT_W-1:0] CLR_LAST   = CNT_W'(CLR_CYC - 1);
   localparam logic [CNT_W-1:0] TRIAL_LAST = CNT_W'(TRIAL_CYC - 1);
   localparam logic [CNT_W-1:0] STORE_LAST = CNT_W'(STORE_CYC - 1);
   localparam logic [IDX_W-1:0] TOP_BIT    = IDX_W'(WIDTH - 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         phase   <= PH_IDLE;
         cnt     <= '0;
         bit_idx <= '0;
      end else if (start) begin
         phase   <= PH_CLEAR;
         cnt     <= '0;
         bit_idx <= TOP_BIT;
      end else begin
         unique case (phase)
            PH_CLEAR: begin
               if (cnt == CLR_LAST) begin
                  phase <= PH_TRIAL;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            PH_TRIAL: begin
               if (cnt == TRIAL_LAST) begin
                  cnt <= '0;
                  if (bit_idx == '0) begin
                     phase <= PH_STORE;
                  end else begin
                     bit_idx <= bit_idx - 1'b1;
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            PH_STORE: begin
               if (cnt == STORE_LAST) begin
                  phase <= PH_IDLE;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: begin
               cnt <= '0;
            end
         endcase
      end
   end

   assign sample     = (phase == PH_TRIAL) && (cnt == TRIAL_LAST);
   assign store_fire = (phase == PH_STORE) && (cnt == STORE_LAST);

   // R4
   bit_step_chk: assert property (@(posedge clk) disable iff (rst)
      (sample && !start && bit_idx != '0) |=> (bit_idx == $past(bit_idx) - 1'b1));

   // R6
   cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_TRIAL) |-> (cnt <= TRIAL_LAST));

endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
   parameter int WIDTH  = 8,
   localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic             in_trial,
   input  logic             sample,
   input  logic [IDX_W-1:0] bit_idx,
   input  logic             cmp_in,
   output logic [WIDTH-1:0] work,
   output logic [WIDTH-1:0] trial_code
);

   logic [WIDTH-1:0] mask;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign mask[i] = in_trial && (bit_idx == IDX_W'(i));

      always_ff @(posedge clk) begin
         if (rst || start) begin
            work[i] <= 1'b0;
         end else if (sample && mask[i]) begin
            work[i] <= cmp_in;
         end
      end
   end

   assign trial_code = work | mask;

   // R4
   mask_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(mask));

   // R5
   work_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (in_trial && !sample && !start) |=> $stable(work));

endmodule

// File: rtl/sar_flags.sv
module sar_flags #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic             store_fire,
   input  logic [WIDTH-1:0] work,
   input  logic             irq_clr,
   output logic [WIDTH-1:0] result,
   output logic             done,
   output logic             irq
);

   logic store_eff;
   assign store_eff = store_fire && !start;

   always_ff @(posedge clk) begin
      if (rst) begin
         result <= '0;
         done   <= 1'b1;
      end else if (start) begin
         result <= '0;
         done   <= 1'b0;
      end else if (store_eff) begin
         result <= work;
         done   <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         irq <= 1'b0;
      end else if (store_eff) begin
         irq <= 1'b1;
      end else if (irq_clr) begin
         irq <= 1'b0;
      end
   end

   // R3
   start_clear_chk: assert property (@(posedge clk) disable iff (rst)
      start |=> (result == '0 && !done));

   // R8
   irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (irq && !irq_clr) |=> irq);

   // R7
   store_irq_chk: assert property (@(posedge clk) disable iff (rst)
      (store_fire && !start) |=> (irq && done));

endmodule

// File: rtl/sar_seq.sv
module sar_seq
   import sar_pkg::*;
#(
   parameter int WIDTH     = 8,
   parameter int TRIAL_CYC = 6,
   parameter int CLR_CYC   = 1,
   parameter int STORE_CYC = 1,
   parameter int CONV_CYC  = 50
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             done_wr,
   input  logic             done_wdata,
   input  logic             irq_clr,
   input  logic             cmp_in,
   output logic [WIDTH-1:0] dac_code,
   output logic [WIDTH-1:0] result,
   output logic             done,
   output logic             irq
);

   localparam int IDX_W  = (WIDTH > 1) ? $clog2(WIDTH) : 1;
   localparam int LEN_W  = $clog2(CONV_CYC + 2);

   if (WIDTH < 1 || TRIAL_CYC < 1 || CLR_CYC < 1 || STORE_CYC < 1) begin : g_bad_param
      $error("sar_seq: every width and phase length must be at least 1");
   end
   if (CLR_CYC + WIDTH * TRIAL_CYC + STORE_CYC != CONV_CYC) begin : g_bad_len
      $error("sar_seq: phase lengths do not add up to CONV_CYC");
   end

   logic             start;
   sar_phase_t       phase;
   logic [IDX_W-1:0] bit_idx;
   logic             sample;
   logic             store_fire;
   logic             in_trial;
   logic [WIDTH-1:0] work;
   logic [WIDTH-1:0] trial_code;

   assign start    = done_wr && !done_wdata;
   assign in_trial = (phase == PH_TRIAL);

   sar_step_timer #(
      .WIDTH     (WIDTH),
      .TRIAL_CYC (TRIAL_CYC),
      .CLR_CYC   (CLR_CYC),
      .STORE_CYC (STORE_CYC)
   ) u_timer (
      .clk        (clk),
      .rst        (rst),
      .start      (start),
      .phase      (phase),
      .bit_idx    (bit_idx),
      .sample     (sample),
      .store_fire (store_fire)
   );

   sar_trial_reg #(
      .WIDTH (WIDTH)
   ) u_trial (
      .clk        (clk),
      .rst        (rst),
      .start      (start),
      .in_trial   (in_trial),
      .sample     (sample),
      .bit_idx    (bit_idx),
      .cmp_in     (cmp_in),
      .work       (work),
      .trial_code (trial_code)
   );

   sar_flags #(
      .WIDTH (WIDTH)
   ) u_flags (
      .clk        (clk),
      .rst        (rst),
      .start      (start),
      .store_fire (store_fire),
      .work       (work),
      .irq_clr    (irq_clr),
      .result     (result),
      .done       (done),
      .irq        (irq)
   );

   assign dac_code = in_trial ? trial_code : '0;

   // Edge count since the latest start, used only by the length check.
   logic [LEN_W-1:0] since_start;
   always_ff @(posedge clk) begin
      if (rst) begin
         since_start <= '0;
      end else if (start) begin
         since_start <= '0;
      end else if (!done && since_start != {LEN_W{1'b1}}) begin
         since_start <= since_start + 1'b1;
      end
   end

   // R6
   conv_len_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(done) |-> (since_start == LEN_W'(CONV_CYC)));

   // R2
   busy_phase_chk: assert property (@(posedge clk) disable iff (rst)
      !done |-> (phase != PH_IDLE));

   // R4
   idle_dac_chk: assert property (@(posedge clk) disable iff (rst)
      !in_trial |-> (dac_code == '0));

endmodule

// File: tb/sar_seq_tb.sv
`timescale 1ns/1ps
module sar_seq_tb;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       done_wr = 1'b0;
   logic       done_wdata = 1'b1;
   logic       irq_clr = 1'b0;
   logic       cmp_in;
   logic [7:0] dac_code;
   logic [7:0] result;
   logic       done;
   logic       irq;

   int  checks = 0;
   int  failures = 0;
   int  vin2 = 0;
   bit  noise = 1'b0;

   always #2.5 clk = ~clk;

   sar_seq u_dut (
      .clk        (clk),
      .rst        (rst),
      .done_wr    (done_wr),
      .done_wdata (done_wdata),
      .irq_clr    (irq_clr),
      .cmp_in     (cmp_in),
      .dac_code   (dac_code),
      .result     (result),
      .done       (done),
      .irq        (irq)
   );

   // Ideal comparator with half-LSB thresholds, levels in half-LSB units.
   int level;
   always_comb begin
      level  = (dac_code == 8'd0) ? 0 : (2 * int'(dac_code) - 1);
      cmp_in = (level < vin2) ^ noise;
   end

   function automatic logic [7:0] exp_code(input int v);
      int n;
      n = v / 2;
      if (n > 255) n = 255;
      return 8'(n);
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      #1000000;
      failures++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      summary();
   end

   task automatic t_reset();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      chk(done == 1'b1, "R1 done", done, 1);
      chk(irq == 1'b0, "R1 irq", irq, 0);
      chk(result == 8'h00, "R1 result", result, 0);
      rst = 1'b0;
      @(negedge clk);
      chk(dac_code == 8'h00, "R1 dac", dac_code, 0);
      chk(done == 1'b1, "R1 done after release", done, 1);
   endtask

   // Full conversion from a start write; optional noise and irq_clr on store edge.
   task automatic run_conv(input int v, input bit noisy, input bit clr_on_store, input string tag);
      logic [7:0] e;
      logic       irq_before;
      vin2 = v;
      e = exp_code(v);
      irq_before = irq;
      done_wr = 1'b1;
      done_wdata = 1'b0;
      @(negedge clk);
      done_wr = 1'b0;
      done_wdata = 1'b1;
      for (int m = 0; m < 50; m++) begin
         if (m > 0) @(negedge clk);
         noise = noisy && (m >= 1) && (m <= 48) && (((m - 1) % 6) != 5);
         irq_clr = clr_on_store && (m == 49);
         if (m == 0) begin
            chk(done == 1'b0, {"R2 busy ", tag}, done, 0);
            chk(result == 8'h00, {"R3 cleared ", tag}, result, 0);
            chk(dac_code == 8'h00, {"R4 clear cycle ", tag}, dac_code, 0);
            chk(irq == irq_before, {"R8 start keeps irq ", tag}, irq, irq_before);
         end
         if (m == 1) chk(dac_code == 8'h80, {"R4 first trial ", tag}, dac_code, 8'h80);
         if (m == 7) chk(dac_code == ((e & 8'h80) | 8'h40), {"R4 second trial ", tag},
                         dac_code, (e & 8'h80) | 8'h40);
         if (m == 25) chk(result == 8'h00, {"R3 mid ", tag}, result, 0);
         if (m == 49) begin
            chk(done == 1'b0, {"R6 not early ", tag}, done, 0);
            chk(dac_code == 8'h00, {"R4 store cycle ", tag}, dac_code, 0);
         end
      end
      @(negedge clk);
      noise = 1'b0;
      irq_clr = 1'b0;
      chk(done == 1'b1, {"R6 done ", tag}, done, 1);
      chk(irq == 1'b1, {"R7 irq ", tag}, irq, 1);
      chk(result == e, {"R10 R5 code ", tag}, result, e);
   endtask

   task automatic t_irq_clear();
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
      chk(irq == 1'b0, "R8 clear", irq, 0);
      repeat (3) @(negedge clk);
      chk(irq == 1'b0, "R8 stays clear", irq, 0);
   endtask

   task automatic t_write_one();
      logic [7:0] r;
      r = result;
      done_wr = 1'b1;
      done_wdata = 1'b1;
      @(negedge clk);
      done_wr = 1'b0;
      chk(done == 1'b1, "R2 write one done", done, 1);
      repeat (10) @(negedge clk);
      chk(result == r, "R2 write one result", result, r);
      chk(dac_code == 8'h00, "R2 write one dac", dac_code, 0);
   endtask

   task automatic t_restart();
      vin2 = 400;
      done_wr = 1'b1;
      done_wdata = 1'b0;
      @(negedge clk);
      done_wr = 1'b0;
      done_wdata = 1'b1;
      repeat (30) @(negedge clk);
      chk(done == 1'b0, "R9 running", done, 0);
      run_conv(61, 1'b0, 1'b0, "R9 restart");
   endtask

   initial begin
      t_reset();
      run_conv(0, 1'b0, 1'b0, "zero");
      run_conv(4, 1'b0, 1'b0, "half-lsb");
      run_conv(1, 1'b0, 1'b0, "below first");
      run_conv(511, 1'b0, 1'b0, "full");
      run_conv(301, 1'b0, 1'b0, "mid");
      t_irq_clear();
      run_conv(200, 1'b1, 1'b0, "R5 noisy");
      run_conv(333, 1'b1, 1'b0, "R5 noisy2");
      t_write_one();
      t_irq_clear();
      run_conv(90, 1'b0, 1'b1, "R8 set wins");
      t_restart();
      t_reset();
      summary();
   end

endmodule